// File: doc/BRIEF.md
# Saturating/Wrapping Signed Arithmetic Unit

This unit does 16-bit signed integer arithmetic. It adds, subtracts, multiplies, divides and negates two operands, and it registers a 16-bit destination value one clock after a valid request. When the true result does not fit in 16 signed bits, the unit handles it in one of two ways, chosen by a mode pin sampled with each request. It either clamps the result to the signed limits or keeps only the low 16 bits.

Every operation updates the carry flag and the overflow flag. An overflow also sets a trap flag, and only an explicit clear input resets it. Multiply and divide also write a 32-bit auxiliary register with the full-precision result. In wrap mode, the carry flag lets a 16-bit value be added to a 32-bit value held as two words. Add the low words first. Then add the carry into the high word. Then add -1 to the high word if the 16-bit value was negative.

Top module: `sat_arith_unit`

## Requirements
- R1: After reset, `out_valid`, `result`, `carry`, `ovf`, `trap` and `mreg` are all zero.
- R2: Operation codes are 0 = ADD (a+b), 1 = SUB (a-b), 2 = MUL (a*b), 3 = DIV (a/b) and 4 = NEG (-a).
  - A request with `in_valid` high and a code from 0 to 4 sets `out_valid` high on the next clock edge. All outputs update on that edge.
  - Codes 5 to 7 are ignored: `out_valid` stays low and no output changes.
- R3: When the true result is in the range -32768 to 32767, `result` equals it exactly. Division truncates toward zero.
- R4: With `wrap_mode` = 0, an out-of-range result writes 32767 (0x7FFF) if the true result is positive, and -32768 (0x8000) if it is negative.
- R5: With `wrap_mode` = 1, an out-of-range result writes the low 16 bits of the true result.
- R6: `ovf` is set by an out-of-range operation and cleared by the next in-range operation. NEG of -32768 and DIV of -32768 by -1 count as out of range.
- R7: `trap` is set on every overflow and stays set across later operations. It is cleared by a cycle with `trap_clr` high. If an overflow and a clear happen on the same edge, the overflow wins and `trap` stays set.
- R8: `carry` has a meaning only for ADD and SUB.
  - For ADD, it is the carry out of the unsigned 16-bit sum.
  - For SUB, it is the borrow, which is set when a < b compared unsigned.
  - For MUL, DIV and NEG, it is 0.
- R9: `mreg` is written only by MUL and DIV, and its value does not depend on `wrap_mode`.
  - MUL writes the full signed 32-bit product.
  - DIV writes the true quotient sign-extended to 32 bits, so -32768 / -1 gives 32768.
  - ADD, SUB and NEG, and division by zero, leave `mreg` unchanged.
- R10: Division by zero in either mode sets `ovf` and `trap`. It writes 32767 if the dividend is zero or positive, and -32768 if the dividend is negative.
- R11: A cycle with `in_valid` low changes neither `result` nor `mreg`, and `out_valid` is low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| a | input | 16 | First operand (signed) |
| b | input | 16 | Second operand (signed) |
| wrap_mode | input | 1 | 0 = saturate, 1 = wrap on overflow |
| trap_clr | input | 1 | Clears the sticky trap flag |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 16 | Destination value |
| carry | output | 1 | Carry (ADD) or borrow (SUB) |
| ovf | output | 1 | Last operation overflowed |
| trap | output | 1 | Sticky overflow trap |
| mreg | output | 32 | Full-precision MUL/DIV result |

## Verification
The state in this unit is the registered result, the flags and the auxiliary register, so a fault shows up at the outputs on the edge right after the request.
- A wrong range test shows as a clamped value where a wrapped one was expected, or the reverse, together with a wrong `ovf`. It is visible in the same cycle as `out_valid`.
- A trap flag that does not hold is caught on the first later in-range operation.
- A corrupted `mreg` persists until the next MUL or DIV. The bench therefore checks it after every operation, including those that must leave it alone.

// File: rtl/sat_arith_unit.sv
module sat_arith_unit #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [2:0]     op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           wrap_mode,
  input  logic           trap_clr,
  output logic           out_valid,
  output logic [W-1:0]   result,
  output logic           carry,
  output logic           ovf,
  output logic           trap,
  output logic [2*W-1:0] mreg
);
  localparam int XW = 2*W + 1;
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2,
                         OP_DIV = 3'd3, OP_NEG = 3'd4;

  logic signed [XW-1:0] ax, bx, bdiv, tr;
  logic [W:0]   usum;
  logic         legal, dz, range_err, ovf_n, carry_n;
  logic [W-1:0] res_n;

  assign ax    = {{(W+1){a[W-1]}}, a};
  assign bx    = {{(W+1){b[W-1]}}, b};
  assign dz    = (op == OP_DIV) && (b == '0);
  assign bdiv  = dz ? XW'(1) : bx;
  assign usum  = {1'b0, a} + {1'b0, b};
  assign legal = (op <= OP_NEG);

  always_comb begin
    tr      = '0;
    carry_n = 1'b0;
    case (op)
      OP_ADD:  begin tr = ax + bx; carry_n = usum[W]; end
      OP_SUB:  begin tr = ax - bx; carry_n = (a < b); end
      OP_MUL:  tr = ax * bx;
      OP_DIV:  tr = ax / bdiv;
      OP_NEG:  tr = -ax;
      default: tr = '0;
    endcase
  end

  assign range_err = !((&tr[XW-1:W-1]) || !(|tr[XW-1:W-1]));
  assign ovf_n     = range_err || dz;

  always_comb begin
    if (dz)             res_n = a[W-1] ? MINV : MAXV;
    else if (!range_err) res_n = tr[W-1:0];
    else if (wrap_mode)  res_n = tr[W-1:0];
    else                 res_n = tr[XW-1] ? MINV : MAXV;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry     <= 1'b0;
      ovf       <= 1'b0;
      trap      <= 1'b0;
      mreg      <= '0;
    end else begin
      out_valid <= in_valid && legal;
      if (in_valid && legal) begin
        result <= res_n;
        carry  <= carry_n;
        ovf    <= ovf_n;
        if ((op == OP_MUL) || (op == OP_DIV && !dz)) mreg <= tr[2*W-1:0];
      end
      if (in_valid && legal && ovf_n) trap <= 1'b1;
      else if (trap_clr)              trap <= 1'b0;
    end
  end

  assert_trap_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap && !trap_clr |=> trap);
  assert_ovf_sets_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> trap);
  assert_sat_limits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && legal && ovf_n && !wrap_mode |=> (result == MAXV) || (result == MINV));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(mreg));
  assert_mul_mreg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_MUL |=> $signed(mreg) == $signed($past(a)) * $signed($past(b)));
  assert_illegal_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !legal |=> !out_valid && $stable(result) && $stable(ovf));
endmodule

// File: tb/sat_arith_unit_tb.sv
module sat_arith_unit_tb;
  logic clk = 1'b0;
  logic rst_n, in_valid, wrap_mode, trap_clr;
  logic [2:0] op;
  logic [15:0] a, b;
  logic out_valid, carry, ovf, trap;
  logic [15:0] result;
  logic [31:0] mreg;

  int checks = 0, failures = 0;
  logic exp_trap = 1'b0;
  logic [31:0] exp_mreg = '0;
  logic [15:0] exp_res = '0;

  always #2.5 clk = ~clk;

  sat_arith_unit u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .wrap_mode(wrap_mode), .trap_clr(trap_clr), .out_valid(out_valid), .result(result),
    .carry(carry), .ovf(ovf), .trap(trap), .mreg(mreg));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic m, input logic clr);
    longint av, bv, t;
    bit dz, ov;
    logic [15:0] er;
    logic ec;
    string tag;
    av = longint'($signed(x));
    bv = longint'($signed(y));
    dz = 0;
    t = 0;
    case (o)
      3'd0: t = av + bv;
      3'd1: t = av - bv;
      3'd2: t = av * bv;
      3'd3: if (bv == 0) dz = 1; else t = av / bv;
      default: t = -av;
    endcase
    ov = dz || t > 32767 || t < -32768;
    if (dz) er = (av >= 0) ? 16'h7FFF : 16'h8000;
    else if (!ov || m) er = t[15:0];
    else er = (t > 0) ? 16'h7FFF : 16'h8000;
    ec = (o == 3'd0) ? (({1'b0, x} + {1'b0, y}) >> 16) != 0 :
         (o == 3'd1) ? (x < y) : 1'b0;
    if (o == 3'd2 || (o == 3'd3 && !dz)) exp_mreg = t[31:0];
    exp_trap = ov ? 1'b1 : (clr ? 1'b0 : exp_trap);
    exp_res = er;
    @(negedge clk);
    in_valid = 1; op = o; a = x; b = y; wrap_mode = m; trap_clr = clr;
    @(negedge clk);
    in_valid = 0; trap_clr = 0;
    tag = dz ? "R10" : (ov ? (m ? "R5" : "R4") : "R3");
    check(out_valid == 1'b1, "R2 out_valid", out_valid, 1);
    check(result == er, tag, result, er);
    check(ovf == ov, "R6 ovf", ovf, ov);
    check(carry == ec, "R8 carry", carry, ec);
    check(trap == exp_trap, "R7 trap", trap, exp_trap);
    check(mreg == exp_mreg, "R9 mreg", mreg, exp_mreg);
  endtask

  initial begin : wd
    #900000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] big, sum32;
    logic [15:0] lo, hi, v;
    void'($urandom(32'd4242));
    rst_n = 0; in_valid = 0; op = 0; a = 0; b = 0; wrap_mode = 0; trap_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({out_valid, result, carry, ovf, trap, mreg} == '0, "R1 reset", result, 0);

    do_op(3'd0, 16'd100, 16'd23, 0, 0);
    do_op(3'd0, 16'h7FFF, 16'd1, 0, 0);
    do_op(3'd1, 16'h8000, 16'd1, 0, 0);
    do_op(3'd0, 16'h7FFF, 16'd1, 1, 0);
    do_op(3'd2, 16'd300, 16'hFF38, 0, 0);
    do_op(3'd2, 16'd300, 16'hFF38, 1, 0);
    do_op(3'd3, 16'hFFF9, 16'd2, 0, 0);
    do_op(3'd3, 16'h8000, 16'hFFFF, 0, 0);
    do_op(3'd3, 16'h8000, 16'hFFFF, 1, 0);
    do_op(3'd4, 16'h8000, 16'd0, 0, 0);
    do_op(3'd4, 16'h8000, 16'd0, 1, 0);
    do_op(3'd3, 16'd0, 16'd0, 1, 0);
    do_op(3'd3, 16'hFFFE, 16'd0, 0, 0);
    do_op(3'd1, 16'd5, 16'd9, 0, 0);

    @(negedge clk); trap_clr = 1;
    @(negedge clk); trap_clr = 0; exp_trap = 0;
    check(trap == 1'b0, "R7 clear", trap, 0);
    do_op(3'd0, 16'h7FFF, 16'h7FFF, 0, 1);

    @(negedge clk); trap_clr = 1;
    @(negedge clk); trap_clr = 0; exp_trap = 0;
    @(negedge clk); in_valid = 1; op = 3'd6; a = 16'h1234; b = 16'h1;
    @(negedge clk); in_valid = 0;
    check(out_valid == 0, "R2 illegal valid", out_valid, 0);
    check(result == exp_res, "R2 illegal result", result, exp_res);
    repeat (2) @(negedge clk);
    check(result == exp_res && mreg == exp_mreg && !out_valid, "R11 idle", result, exp_res);

    big = 32'h0001_FFF0; v = 16'hFFE0;
    do_op(3'd0, big[15:0], v, 1, 0);
    lo = result;
    do_op(3'd0, big[31:16], {15'd0, carry}, 1, 0);
    hi = result;
    if (v[15]) begin do_op(3'd0, hi, 16'hFFFF, 1, 0); hi = result; end
    sum32 = big + {{16{v[15]}}, v};
    check({hi, lo} == sum32, "R8 chain32", {hi, lo}, sum32);
    big = 32'h0000_FFF0; v = 16'h0020;
    do_op(3'd0, big[15:0], v, 1, 0);
    lo = result;
    do_op(3'd0, big[31:16], {15'd0, carry}, 1, 0);
    hi = result;
    sum32 = big + {{16{v[15]}}, v};
    check({hi, lo} == sum32, "R8 chain32 up", {hi, lo}, sum32);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ro;
      logic [15:0] ra, rb;
      ro = 3'($urandom_range(0, 4));
      ra = 16'($urandom);
      rb = 16'($urandom);
      if ($urandom_range(0, 7) == 0) rb = 16'($urandom_range(0, 2)) - 16'd1;
      if ($urandom_range(0, 7) == 0) ra = 16'h8000;
      do_op(ro, ra, rb, 1'($urandom), 1'($urandom_range(0, 3) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule